// File: doc/BRIEF.md
# Latch-Enable Framed Serial Configuration Register Slave

This block is a serial slave that lets a host write and read a bank of nine 28-bit configuration registers over four wires: a serial clock, a data-in line, a data-out line and an active-low latch-enable that frames every transfer. Each frame is 32 bits long. A 4-bit address comes first, followed by 28 data bits, and both go most significant bit first. Every register is also presented in parallel on a wide output, so downstream logic can use the configuration directly.

The serial lines are asynchronous to the block's system clock. They pass through two-flop synchronizers, and their edges are found in the system clock domain. For this reason the system clock must run at least four times faster than the serial clock. A write takes effect when latch-enable returns high, and only if the frame held exactly 32 bits.

A read uses two frames. The first is a read command: address field 15, with the target register number in the four least significant data bits. During the frame that follows, the slave drives four zero bits and then the register contents, MSB first. In that frame the bits the host shifts in are ignored.

Top module: `lecfg_spi_slave`

## Requirements
- R1: After reset all nine registers read zero on the parallel output and the data-out line is low.
- R2: A frame of exactly 32 bits, with bits sampled on rising serial-clock edges while latch-enable is low, and bits 31..28 an address 0 to 8 and bits 27..0 data, loads that data into the addressed register when latch-enable rises.
- R3: A frame with fewer or more than 32 clocked bits changes no register and arms no read, whatever its content.
- R4: A full frame with an address from 9 to 14 changes no register.
- R5: Serial-clock and data-in activity while latch-enable is high has no effect on any register or on the data-out line.
- R6: A full frame with address 15 arms a read of the register named by its data bits 3..0. In the next frame data-out gives four zero bits and then the 28 register bits, MSB first, each bit valid at the following rising serial-clock edge and changing after a falling edge. Bits shifted in during that frame write nothing.
- R7: A read armed for a target from 9 to 15 returns 28 zero bits.
- R8: The data-out line is held low whenever latch-enable is high, including while a read is armed.
- R9: An armed read is consumed by the very next frame. The frame after a readout frame drives zeros on data-out and is decoded as a normal write.
- R10: A frame whose latch-enable rises at the same instant as its 32nd rising serial-clock edge still counts that bit and commits the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_le_n | input | 1 | Active-low latch-enable that frames a transfer |
| spi_din | input | 1 | Serial data from the host |
| spi_dout | output | 1 | Serial readback data to the host |
| cfg_regs | output | 252 | All registers in parallel, register k at bits [28k+27:28k] |

## Verification
Two events can land in the same system-clock cycle: the last rising serial-clock edge of a frame and the rising edge of latch-enable. Both pass through synchronizers of equal depth, so the shift of bit 32 and the commit decision coincide. The bench provokes this by raising latch-enable in the same simulation step as the final serial-clock rise. It then judges the result by comparing the parallel output with its own register model, and by reading that register back through a two-frame read. A second overlap, where a read is armed at one frame's end and consumed at the next frame's start, is judged by checking the readback bits and checking that the readout frame's own bits wrote nothing.

// File: rtl/lecfg_pkg.sv
`timescale 1ns/1ps
package lecfg_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 28;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam logic [ADDR_W-1:0] READ_CMD = '1;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [DATA_W-1:0]  data_t;
  typedef logic [FRAME_W-1:0] frame_t;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_WRITE,
    ACT_ARM_READ
  } frame_act_e;

  function automatic addr_t frame_addr(frame_t f);
    return f[FRAME_W-1 -: ADDR_W];
  endfunction

  function automatic data_t frame_data(frame_t f);
    return f[DATA_W-1:0];
  endfunction

  function automatic addr_t frame_target(frame_t f);
    return f[ADDR_W-1:0];
  endfunction

  function automatic logic addr_decoded(addr_t a, int unsigned nregs);
    return int'(a) < int'(nregs);
  endfunction

  // Decide what a closed frame does
  function automatic frame_act_e classify(frame_t f, logic full, logic readout,
                                          int unsigned nregs);
    if (!full || readout)                return ACT_NONE;
    if (frame_addr(f) == READ_CMD)       return ACT_ARM_READ;
    if (addr_decoded(frame_addr(f), nregs)) return ACT_WRITE;
    return ACT_NONE;
  endfunction

  // Readback word: zero in the address slot, register in the data slot
  function automatic frame_t readout_word(data_t d);
    return {{ADDR_W{1'b0}}, d};
  endfunction
endpackage

// File: rtl/lecfg_sync.sv
`timescale 1ns/1ps
module lecfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lecfg_frame.sv
`timescale 1ns/1ps
module lecfg_frame
  import lecfg_pkg::*;
#(
  parameter int NUM_REGS = 9
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_s,
  input  logic  le_n_s,
  input  logic  din_s,
  input  logic  readout_frame,
  output logic  sclk_fall,
  output logic  le_fall,
  output logic  le_rise,
  output logic  wr_en,
  output addr_t wr_addr,
  output data_t wr_data,
  output logic  arm_en,
  output addr_t arm_target
);
  localparam int CNT_SAT = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_SAT + 1);

  logic             sclk_d, le_n_d;
  logic             sclk_rise, shift_en;
  frame_t           shift_q, shift_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             frame_full;
  frame_act_e       act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      le_n_d <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      le_n_d <= le_n_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign le_fall   = ~le_n_s & le_n_d;
  assign le_rise   = le_n_s & ~le_n_d;
  // previous-cycle latch-enable gates shifting so a final edge coinciding
  // with the closing edge is still taken
  assign shift_en  = sclk_rise & ~le_n_d;

  always_comb begin
    shift_nx = shift_q;
    cnt_nx   = cnt_q;
    if (le_fall) begin
      shift_nx = '0;
      cnt_nx   = '0;
    end else if (shift_en) begin
      shift_nx = {shift_q[FRAME_W-2:0], din_s};
      if (cnt_q != CNT_W'(CNT_SAT)) cnt_nx = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      shift_q <= shift_nx;
      cnt_q   <= cnt_nx;
    end
  end

  assign frame_full = (cnt_nx == CNT_W'(FRAME_W));
  assign act        = classify(shift_nx, frame_full, readout_frame, NUM_REGS);
  assign wr_en      = le_rise && (act == ACT_WRITE);
  assign arm_en     = le_rise && (act == ACT_ARM_READ);
  assign wr_addr    = frame_addr(shift_nx);
  assign wr_data    = frame_data(shift_nx);
  assign arm_target = frame_target(shift_nx);

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (le_n_s && le_n_d) |=> $stable(shift_q)) else $error("shift while idle"); // R5
  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, arm_en})) else $error("write and arm together"); // R6
endmodule

// File: rtl/lecfg_regbank.sv
`timescale 1ns/1ps
module lecfg_regbank
  import lecfg_pkg::*;
#(
  parameter int NUM_REGS = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  addr_t                      wr_addr,
  input  data_t                      wr_data,
  input  addr_t                      rd_addr,
  output data_t                      rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  data_t regs_q [NUM_REGS];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs_q[g] <= '0;
        else if (wr_en && addr_decoded(wr_addr, NUM_REGS) && (wr_addr == ADDR_W'(g)))
          regs_q[g] <= wr_data;
      end
      assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
    end
  endgenerate

  // undecoded addresses fall through to zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs_q[i];
  end

  AST_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_flat) |-> $past(wr_en)) else $error("register changed without write"); // R2
  AST_WRITE_ADDR_DECODED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < NUM_REGS)) else $error("write to undecoded address"); // R4
endmodule

// File: rtl/lecfg_readout.sv
`timescale 1ns/1ps
module lecfg_readout
  import lecfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  le_n_s,
  input  logic  le_fall,
  input  logic  le_rise,
  input  logic  sclk_fall,
  input  logic  arm_en,
  input  addr_t arm_target,
  input  data_t rd_data,
  output addr_t rd_addr,
  output logic  readout_frame,
  output logic  dout
);
  logic   armed_q;
  addr_t  target_q;
  logic   readout_q;
  frame_t out_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      target_q  <= '0;
      readout_q <= 1'b0;
      out_sr    <= '0;
    end else begin
      if (le_fall) begin
        readout_q <= armed_q;
        out_sr    <= armed_q ? readout_word(rd_data) : '0;
        armed_q   <= 1'b0;
      end else if (sclk_fall && !le_n_s) begin
        out_sr <= {out_sr[FRAME_W-2:0], 1'b0};
      end
      if (le_rise) begin
        readout_q <= 1'b0;
        if (arm_en) begin
          armed_q  <= 1'b1;
          target_q <= arm_target;
        end
      end
    end
  end

  assign rd_addr       = target_q;
  assign readout_frame = readout_q;
  assign dout          = !le_n_s && out_sr[FRAME_W-1];

  AST_ARM_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(arm_en)) else $error("read armed without command"); // R6
endmodule

// File: rtl/lecfg_spi_slave.sv
`timescale 1ns/1ps
module lecfg_spi_slave
  import lecfg_pkg::*;
#(
  parameter int NUM_REGS    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_sclk,
  input  logic                       spi_le_n,
  input  logic                       spi_din,
  output logic                       spi_dout,
  output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
  logic  sclk_s, le_n_s, din_s;
  logic  sclk_fall, le_fall, le_rise;
  logic  wr_en, arm_en, readout_frame;
  addr_t wr_addr, arm_target, rd_addr;
  data_t wr_data, rd_data;

  lecfg_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({spi_sclk, spi_le_n, spi_din}),
    .q    ({sclk_s, le_n_s, din_s})
  );

  lecfg_frame #(.NUM_REGS(NUM_REGS)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_s       (sclk_s),
    .le_n_s       (le_n_s),
    .din_s        (din_s),
    .readout_frame(readout_frame),
    .sclk_fall    (sclk_fall),
    .le_fall      (le_fall),
    .le_rise      (le_rise),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .arm_en       (arm_en),
    .arm_target   (arm_target)
  );

  lecfg_regbank #(.NUM_REGS(NUM_REGS)) u_regbank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .regs_flat(cfg_regs)
  );

  lecfg_readout u_readout (
    .clk          (clk),
    .rst_n        (rst_n),
    .le_n_s       (le_n_s),
    .le_fall      (le_fall),
    .le_rise      (le_rise),
    .sclk_fall    (sclk_fall),
    .arm_en       (arm_en),
    .arm_target   (arm_target),
    .rd_data      (rd_data),
    .rd_addr      (rd_addr),
    .readout_frame(readout_frame),
    .dout         (spi_dout)
  );

  AST_DOUT_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    le_n_s |-> !spi_dout) else $error("data-out driven while idle"); // R8
endmodule

// File: tb/test_lecfg_spi_slave.sv
`timescale 1ns/1ps
module test_lecfg_spi_slave;
  import lecfg_pkg::*;
  localparam int NREG = 9;
  localparam int HALF = 80;
  localparam int FW   = NREG * DATA_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, le_n = 1'b1, din = 1'b0;
  logic dout;
  logic [FW-1:0] regs;
  int checks = 0, errors = 0;
  logic [DATA_W-1:0] mdl [NREG];

  always #5 clk = ~clk;

  lecfg_spi_slave i_lecfg_spi_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_le_n(le_n),
    .spi_din(din), .spi_dout(dout), .cfg_regs(regs)
  );

  typedef struct packed {
    logic [5:0]  nbits;
    logic [3:0]  addr;
    logic [27:0] data;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{6'd32, 4'h0, 28'h0ABCDEF},
    '{6'd32, 4'h8, 28'hFFFFFFF},
    '{6'd32, 4'h9, 28'h1234567},
    '{6'd32, 4'hE, 28'h7654321},
    '{6'd31, 4'h1, 28'h1111111},
    '{6'd33, 4'h2, 28'h2222222},
    '{6'd32, 4'h3, 28'h5A5A5A5},
    '{6'd32, 4'h0, 28'h0000001},
    '{6'd0,  4'h4, 28'h4444444},
    '{6'd32, 4'h7, 28'h8000000}
  };

  function automatic logic [FW-1:0] model_flat();
    logic [FW-1:0] f;
    for (int k = 0; k < NREG; k++) f[k*DATA_W +: DATA_W] = mdl[k];
    return f;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_write(input logic [3:0] a, input logic [27:0] d, input int n);
    if (n == 32 && a < NREG) mdl[a] = d;
  endtask

  // one framed transfer; rx collects data-out sampled before each rising edge
  task automatic xfer(input logic [31:0] word, input int nbits, input bit le_on_last,
                      output logic [31:0] rx);
    rx   = '0;
    le_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      din = (i < 32) ? word[31-i] : 1'b0;
      #HALF;
      if (i < 32) rx[31-i] = dout;
      sclk = 1'b1;
      if (le_on_last && i == nbits - 1) le_n = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
    if (!le_on_last || nbits == 0) begin
      #HALF;
      le_n = 1'b1;
    end
    din = 1'b0;
    #(4*HALF);
  endtask

  task automatic read_reg(input logic [3:0] tgt, input logic [31:0] payload,
                          output logic [31:0] rx);
    logic [31:0] dummy;
    xfer({4'hF, 24'h0, tgt}, 32, 1'b0, dummy);
    xfer(payload, 32, 1'b0, rx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rx;
    bit bad;
    for (int k = 0; k < NREG; k++) mdl[k] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "registers after reset", regs, '0);
    chk("R1", "data-out after reset", FW'(dout), '0);

    // table walk: R2 writes, R3 bad lengths, R4 undecoded addresses
    for (int v = 0; v < 10; v++) begin
      string req;
      xfer({VEC[v].addr, VEC[v].data}, int'(VEC[v].nbits), 1'b0, rx);
      model_write(VEC[v].addr, VEC[v].data, int'(VEC[v].nbits));
      if (VEC[v].nbits != 6'd32)   req = "R3";
      else if (VEC[v].addr >= NREG) req = "R4";
      else                          req = "R2";
      chk(req, $sformatf("vector %0d", v), regs, model_flat());
    end

    // R5: clocking with latch-enable high
    for (int i = 0; i < 40; i++) begin
      din = 1'b1; #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
    end
    din = 1'b0;
    #(4*HALF);
    chk("R5", "registers after idle clocking", regs, model_flat());
    chk("R5", "data-out after idle clocking", FW'(dout), '0);

    // R6/R8: arm read of register 8, data-out must stay low while idle
    xfer({4'hF, 24'h0, 4'h8}, 32, 1'b0, rx);
    bad = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (dout !== 1'b0) bad = 1'b1;
    end
    chk("R8", "data-out while read armed", FW'(bad), '0);
    xfer({4'h0, 28'h1234567}, 32, 1'b0, rx);
    chk("R6", "readback of register 8", FW'(rx), FW'({4'h0, mdl[8]}));
    chk("R6", "readout frame wrote nothing", regs, model_flat());

    // R9: next frame is normal
    xfer({4'h5, 28'h0DEAD01}, 32, 1'b0, rx);
    model_write(4'h5, 28'h0DEAD01, 32);
    chk("R9", "data-out after readout", FW'(rx), '0);
    chk("R9", "write after readout", regs, model_flat());

    read_reg(4'h3, 32'h0, rx);
    chk("R6", "readback of register 3", FW'(rx), FW'({4'h0, mdl[3]}));

    // R7: undecoded read targets
    read_reg(4'hC, 32'h0, rx);
    chk("R7", "read of target 12", FW'(rx), '0);
    read_reg(4'h9, 32'h0, rx);
    chk("R7", "read of target 9", FW'(rx), '0);

    // R3: short read command does not arm
    xfer({4'hF, 24'h0, 4'h8}, 31, 1'b0, rx);
    xfer({4'h2, 28'h0FEDCBA}, 32, 1'b0, rx);
    model_write(4'h2, 28'h0FEDCBA, 32);
    chk("R3", "short read command left nothing armed", FW'(rx), '0);
    chk("R3", "following frame decoded as write", regs, model_flat());

    // R10: latch-enable rises with the final rising clock edge
    xfer({4'h6, 28'h3C3C3C3}, 32, 1'b1, rx);
    model_write(4'h6, 28'h3C3C3C3, 32);
    chk("R10", "coincident close commits", regs, model_flat());
    read_reg(4'h6, 32'h0, rx);
    chk("R10", "readback after coincident close", FW'(rx), FW'({4'h0, mdl[6]}));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule